// File: doc/BRIEF.md
# Horizontal Phase Detector Gate Controller

This block decides when the first horizontal phase-locked loop may compare the incoming sync against its own oscillator, and how quickly that loop reacts. A sub-line tick advances a position counter inside each line, and a line counter advances across the field. A vertical sync reference restarts both counters. From these counters, the field-rate standard and a noise flag, the block drives a gate that enables the phase detector.

Outside the vertical-retrace lines the detector runs ungated. On the retrace lines it is opened only for a wide pulse at the start of each line, so that copy-protection pulses in that part of the field cannot pull the loop. When noise is reported, every line is gated with a narrow pulse instead.

A separate selector turns the two host time-constant bits, the noise and lock flags, the video-identification flag and two override controls into a loop speed code. In fast mode, a boost strobe raises the detector current during the gated retrace pulses. This lets head-switch phase steps settle within the retrace.

Top module: `hpd_gate_ctrl`

## Requirements
- R1: After reset the line count is 0 and the position count is 0. Line 0 lies outside the retrace window, so with noise low and the loop not off, `pd_gate` is 1 and `boost` is 0.
- R2: A high `vsync_ref` at a clock edge sets the line count to 1 and the position to 0, overriding `tick_en`. Otherwise each `tick_en` advances the position. After position 439 (TICKS_PER_LINE-1) the position returns to 0 and the line count increments, saturating at its maximum.
- R3: With `field60` = 1 the retrace window is lines 11 to 17 inclusive. On those lines, without noise, `pd_gate` is 1 for positions 0 to 150 (151 ticks, about 22 µs) and 0 for the rest of the line.
- R4: With `field60` = 0 the retrace window is lines 11 to 22 inclusive, with the same wide pulse.
- R5: On lines outside the window, with noise low and the loop not off, `pd_gate` stays at 1 for the whole line.
- R6: While `noise_det` is 1, every line, inside or outside the window, is gated with a narrow pulse: `pd_gate` is 1 for positions 0 to 38 (39 ticks, about 5.7 µs) and 0 otherwise.
- R7: `speed_code` encodes 00 slow, 01 fast, 10 fixed OSD, 11 off. With `tc_bits` = 00 it is slow under noise, fast when `line_locked` is 0, and slow otherwise. `tc_bits` = 01 gives slow. `tc_bits` = 10 gives fast, or slow under noise. `tc_bits` = 11 gives fast.
- R8: When `video_ident` is 0 and `osd_revoke` is 0, `speed_code` is 10 (OSD) regardless of `tc_bits`. Setting `osd_revoke` to 1 returns control to `tc_bits`.
- R9: `loop_off` = 1 overrides everything: `speed_code` is 11, and `pd_gate` and `boost` are 0.
- R10: `boost` is 1 exactly when `speed_code` is fast, the current line is inside the retrace window and `pd_gate` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Sub-line time base tick |
| vsync_ref | input | 1 | Vertical sync reference, restarts the line count |
| field60 | input | 1 | 1 = 60 Hz standard, 0 = 50 Hz |
| noise_det | input | 1 | Noise detector flag |
| line_locked | input | 1 | Coincidence (lock) flag |
| video_ident | input | 1 | Video present flag |
| osd_revoke | input | 1 | Disables the video-ident coupling into OSD mode |
| loop_off | input | 1 | Switches the loop off |
| tc_bits | input | 2 | Host time-constant selection |
| pd_gate | output | 1 | Phase detector enable |
| speed_code | output | 2 | Loop speed code |
| boost | output | 1 | Detector current boost strobe |

## Verification
The bench targets both edges of the retrace window for each standard: lines 10 and 11, lines 17 and 18 at 60 Hz, and lines 22 and 23 at 50 Hz. An off-by-one comparison would gate a line that should run ungated, or leave one retrace line ungated. It also samples the last tick inside each pulse width and the tick just after. A counter that is wrong by one would close the detector a tick early or hold it open a tick late. Each priority of the speed selector is driven through a vector table; a wrong ordering would let noise override the forced-fast setting, or let OSD mode beat the off control. The boost strobe is checked on a window line in fast mode, after its pulse, on a line outside the window, and in slow mode, which exposes a strobe not tied to the window or the gate.

// File: rtl/hpd_pkg.sv
package hpd_pkg;

   typedef enum logic [1:0] {
      SPD_SLOW = 2'b00,
      SPD_FAST = 2'b01,
      SPD_OSD  = 2'b10,
      SPD_OFF  = 2'b11
   } speed_t;

   typedef enum logic [1:0] {
      TC_AUTO     = 2'b00,
      TC_SLOW     = 2'b01,
      TC_NOISEDEP = 2'b10,
      TC_FAST     = 2'b11
   } tc_t;

endpackage

// File: rtl/hpd_timebase.sv
module hpd_timebase #(
   parameter int TICKS_PER_LINE = 440,
   parameter int LINE_W         = 10,
   parameter int TICK_W         = $clog2(TICKS_PER_LINE)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              vsync_ref,
   output logic [LINE_W-1:0] line_q,
   output logic [TICK_W-1:0] pos_q
);

   localparam logic [TICK_W-1:0] LAST_POS = TICK_W'(TICKS_PER_LINE - 1);
   localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};
   localparam logic [LINE_W-1:0] LINE_ONE = LINE_W'(1);

   generate
      if (TICKS_PER_LINE < 2) begin : g_bad_ticks
         $error("hpd_timebase: TICKS_PER_LINE must be at least 2");
      end
      if (LINE_W < 5) begin : g_bad_linew
         $error("hpd_timebase: LINE_W too narrow for retrace lines");
      end
   endgenerate

   logic wrap;
   assign wrap = tick_en && (pos_q == LAST_POS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_q <= '0;
      end else if (vsync_ref) begin
         pos_q <= '0;
      end else if (wrap) begin
         pos_q <= '0;
      end else if (tick_en) begin
         pos_q <= pos_q + TICK_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_q <= '0;
      end else if (vsync_ref) begin
         line_q <= LINE_ONE;
      end else if (wrap && (line_q != LINE_MAX)) begin
         line_q <= line_q + LINE_ONE;
      end
   end

endmodule

// File: rtl/hpd_window.sv
module hpd_window #(
   parameter int TICKS_PER_LINE = 440,
   parameter int LINE_W         = 10,
   parameter int TICK_W         = $clog2(TICKS_PER_LINE),
   parameter int WIN_START      = 11,
   parameter int WIN_END_60     = 17,
   parameter int WIN_END_50     = 22,
   parameter int WIDE_TICKS     = 151,
   parameter int NARROW_TICKS   = 39
) (
   input  logic [LINE_W-1:0] line_q,
   input  logic [TICK_W-1:0] pos_q,
   input  logic              field60,
   input  logic              noise_det,
   input  logic              loop_off,
   output logic              in_window,
   output logic              pd_gate
);

   localparam logic [LINE_W-1:0] START_L = LINE_W'(WIN_START);
   localparam logic [LINE_W-1:0] END60_L = LINE_W'(WIN_END_60);
   localparam logic [LINE_W-1:0] END50_L = LINE_W'(WIN_END_50);
   localparam logic [TICK_W-1:0] WIDE_L  = TICK_W'(WIDE_TICKS);
   localparam logic [TICK_W-1:0] NARR_L  = TICK_W'(NARROW_TICKS);

   generate
      if (WIDE_TICKS >= TICKS_PER_LINE || WIDE_TICKS < 1) begin : g_bad_wide
         $error("hpd_window: WIDE_TICKS must lie within one line");
      end
      if (NARROW_TICKS > WIDE_TICKS || NARROW_TICKS < 1) begin : g_bad_narrow
         $error("hpd_window: NARROW_TICKS must not exceed WIDE_TICKS");
      end
      if (WIN_END_60 < WIN_START || WIN_END_50 < WIN_START) begin : g_bad_win
         $error("hpd_window: window end precedes window start");
      end
      if (WIN_END_50 >= (1 << LINE_W) || WIN_END_60 >= (1 << LINE_W)) begin : g_bad_range
         $error("hpd_window: window end exceeds line counter range");
      end
   endgenerate

   logic [LINE_W-1:0] win_end;
   logic              wide_on;
   logic              narrow_on;

   always_comb begin
      win_end   = field60 ? END60_L : END50_L;
      in_window = (line_q >= START_L) && (line_q <= win_end);
      wide_on   = pos_q < WIDE_L;
      narrow_on = pos_q < NARR_L;
   end

   always_comb begin
      if (loop_off) begin
         pd_gate = 1'b0;
      end else if (noise_det) begin
         pd_gate = narrow_on;
      end else if (in_window) begin
         pd_gate = wide_on;
      end else begin
         pd_gate = 1'b1;
      end
   end

endmodule

// File: rtl/hpd_speed_sel.sv
module hpd_speed_sel
   import hpd_pkg::*;
(
   input  logic [1:0] tc_bits,
   input  logic       noise_det,
   input  logic       line_locked,
   input  logic       video_ident,
   input  logic       osd_revoke,
   input  logic       loop_off,
   output speed_t     speed
);

   speed_t tc_speed;

   always_comb begin
      unique case (tc_t'(tc_bits))
         TC_AUTO: begin
            if (noise_det)         tc_speed = SPD_SLOW;
            else if (!line_locked) tc_speed = SPD_FAST;
            else                   tc_speed = SPD_SLOW;
         end
         TC_SLOW:     tc_speed = SPD_SLOW;
         TC_NOISEDEP: tc_speed = noise_det ? SPD_SLOW : SPD_FAST;
         default:     tc_speed = SPD_FAST;
      endcase
   end

   always_comb begin
      if (loop_off) begin
         speed = SPD_OFF;
      end else if (!video_ident && !osd_revoke) begin
         speed = SPD_OSD;
      end else begin
         speed = tc_speed;
      end
   end

endmodule

// File: rtl/hpd_gate_ctrl.sv
module hpd_gate_ctrl
   import hpd_pkg::*;
#(
   parameter int TICKS_PER_LINE = 440,
   parameter int LINE_W         = 10,
   parameter int WIN_START      = 11,
   parameter int WIN_END_60     = 17,
   parameter int WIN_END_50     = 22,
   parameter int WIDE_TICKS     = 151,
   parameter int NARROW_TICKS   = 39
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_en,
   input  logic       vsync_ref,
   input  logic       field60,
   input  logic       noise_det,
   input  logic       line_locked,
   input  logic       video_ident,
   input  logic       osd_revoke,
   input  logic       loop_off,
   input  logic [1:0] tc_bits,
   output logic       pd_gate,
   output logic [1:0] speed_code,
   output logic       boost
);

   localparam int TICK_W = $clog2(TICKS_PER_LINE);

   logic [LINE_W-1:0] line_q;
   logic [TICK_W-1:0] pos_q;
   logic              in_window;
   speed_t            speed;

   hpd_timebase #(
      .TICKS_PER_LINE(TICKS_PER_LINE),
      .LINE_W        (LINE_W),
      .TICK_W        (TICK_W)
   ) u_tb (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_en  (tick_en),
      .vsync_ref(vsync_ref),
      .line_q   (line_q),
      .pos_q    (pos_q)
   );

   hpd_window #(
      .TICKS_PER_LINE(TICKS_PER_LINE),
      .LINE_W        (LINE_W),
      .TICK_W        (TICK_W),
      .WIN_START     (WIN_START),
      .WIN_END_60    (WIN_END_60),
      .WIN_END_50    (WIN_END_50),
      .WIDE_TICKS    (WIDE_TICKS),
      .NARROW_TICKS  (NARROW_TICKS)
   ) u_win (
      .line_q   (line_q),
      .pos_q    (pos_q),
      .field60  (field60),
      .noise_det(noise_det),
      .loop_off (loop_off),
      .in_window(in_window),
      .pd_gate  (pd_gate)
   );

   hpd_speed_sel u_spd (
      .tc_bits    (tc_bits),
      .noise_det  (noise_det),
      .line_locked(line_locked),
      .video_ident(video_ident),
      .osd_revoke (osd_revoke),
      .loop_off   (loop_off),
      .speed      (speed)
   );

   assign speed_code = speed;
   assign boost      = (speed == SPD_FAST) && in_window && pd_gate;

endmodule

// File: rtl/hpd_gate_ctrl_chk.sv
module hpd_gate_ctrl_chk #(
   parameter int LINE_W       = 10,
   parameter int TICK_W       = 9,
   parameter int WIN_START    = 11,
   parameter int WIN_END_60   = 17,
   parameter int WIN_END_50   = 22,
   parameter int NARROW_TICKS = 39
) (
   input logic              clk,
   input logic              rst_n,
   input logic              vsync_ref,
   input logic              field60,
   input logic              noise_det,
   input logic              video_ident,
   input logic              osd_revoke,
   input logic              loop_off,
   input logic              pd_gate,
   input logic [1:0]        speed_code,
   input logic              boost,
   input logic [LINE_W-1:0] line_q,
   input logic [TICK_W-1:0] pos_q
);

   localparam logic [LINE_W-1:0] START_L = LINE_W'(WIN_START);
   localparam logic [LINE_W-1:0] END60_L = LINE_W'(WIN_END_60);
   localparam logic [LINE_W-1:0] END50_L = LINE_W'(WIN_END_50);
   localparam logic [TICK_W-1:0] NARR_L  = TICK_W'(NARROW_TICKS);

   logic outside;
   assign outside = (line_q < START_L) || (line_q > (field60 ? END60_L : END50_L));

   assert_vsync_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
      vsync_ref |=> (line_q == LINE_W'(1)) && (pos_q == '0));

   assert_ungated_outside_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!noise_det && !loop_off && outside) |-> pd_gate);

   assert_narrow_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (noise_det && pos_q >= NARR_L) |-> !pd_gate);

   assert_osd_force_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!loop_off && !video_ident && !osd_revoke) |-> (speed_code == 2'b10));

   assert_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      loop_off |-> (!pd_gate && !boost && speed_code == 2'b11));

   assert_boost_needs_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
      boost |-> (pd_gate && speed_code == 2'b01 && !outside));

endmodule

bind hpd_gate_ctrl hpd_gate_ctrl_chk #(
   .LINE_W      (LINE_W),
   .TICK_W      (TICK_W),
   .WIN_START   (WIN_START),
   .WIN_END_60  (WIN_END_60),
   .WIN_END_50  (WIN_END_50),
   .NARROW_TICKS(NARROW_TICKS)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .vsync_ref  (vsync_ref),
   .field60    (field60),
   .noise_det  (noise_det),
   .video_ident(video_ident),
   .osd_revoke (osd_revoke),
   .loop_off   (loop_off),
   .pd_gate    (pd_gate),
   .speed_code (speed_code),
   .boost      (boost),
   .line_q     (line_q),
   .pos_q      (pos_q)
);

// File: tb/hpd_gate_ctrl_test.sv
module hpd_gate_ctrl_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic       vsync_ref = 1'b0;
   logic       field60 = 1'b1;
   logic       noise_det = 1'b0;
   logic       line_locked = 1'b1;
   logic       video_ident = 1'b1;
   logic       osd_revoke = 1'b0;
   logic       loop_off = 1'b0;
   logic [1:0] tc_bits = 2'b00;
   logic       pd_gate;
   logic [1:0] speed_code;
   logic       boost;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #5 clk = ~clk;

   hpd_gate_ctrl uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_en    (tick_en),
      .vsync_ref  (vsync_ref),
      .field60    (field60),
      .noise_det  (noise_det),
      .line_locked(line_locked),
      .video_ident(video_ident),
      .osd_revoke (osd_revoke),
      .loop_off   (loop_off),
      .tc_bits    (tc_bits),
      .pd_gate    (pd_gate),
      .speed_code (speed_code),
      .boost      (boost)
   );

   // vector: {tc[1:0], noise, locked, vid, revoke, off, expected speed[1:0]}
   localparam int NVEC = 11;
   localparam logic [8:0] VEC [NVEC] = '{
      {2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00},
      {2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b01},
      {2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00},
      {2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00},
      {2'b10, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'b01},
      {2'b10, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00},
      {2'b11, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 2'b01},
      {2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b10},
      {2'b11, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'b01},
      {2'b01, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 2'b11},
      {2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'b11}
   };

   task automatic chk(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Restart the field, then stop at the given line and position.
   task automatic goto(input int ln, input int pos);
      @(negedge clk);
      vsync_ref = 1'b1;
      tick_en   = 1'b1;
      @(posedge clk);
      @(negedge clk);
      vsync_ref = 1'b0;
      repeat ((ln - 1) * 440 + pos) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic advance(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state, line 0 is outside the window
      chk("R1 gate after reset", pd_gate, 1);
      chk("R1 boost after reset", boost, 0);

      // R7 R8 R9: speed selection table
      for (int i = 0; i < NVEC; i++) begin
         @(negedge clk);
         {tc_bits, noise_det, line_locked, video_ident, osd_revoke, loop_off} = VEC[i][8:2];
         #1;
         chk($sformatf("R7/R8/R9 vec %0d speed", i), speed_code, VEC[i][1:0]);
      end
      @(negedge clk);
      tc_bits = 2'b01; noise_det = 1'b0; line_locked = 1'b1;
      video_ident = 1'b1; osd_revoke = 1'b0; loop_off = 1'b0;

      // R2 R3: 60 Hz window and wide pulse edges
      field60 = 1'b1;
      goto(11, 0);
      chk("R3 line 11 pos 0 gate", pd_gate, 1);
      advance(150);
      chk("R3 line 11 pos 150 gate", pd_gate, 1);
      advance(1);
      chk("R3 line 11 pos 151 gate", pd_gate, 0);
      goto(17, 200);
      chk("R3 line 17 pos 200 gate", pd_gate, 0);
      advance(440);
      chk("R3 R5 line 18 pos 200 gate", pd_gate, 1);
      goto(10, 300);
      chk("R2 R5 line 10 pos 300 gate", pd_gate, 1);

      // R4: 50 Hz window end
      field60 = 1'b0;
      goto(22, 200);
      chk("R4 line 22 pos 200 gate", pd_gate, 0);
      advance(440);
      chk("R4 line 23 pos 200 gate", pd_gate, 1);
      goto(18, 300);
      chk("R4 line 18 pos 300 gate", pd_gate, 0);

      // R6: narrow gating on every line under noise
      noise_det = 1'b1;
      goto(5, 38);
      chk("R6 line 5 pos 38 gate", pd_gate, 1);
      advance(1);
      chk("R6 line 5 pos 39 gate", pd_gate, 0);
      goto(12, 100);
      chk("R6 line 12 pos 100 gate", pd_gate, 0);
      noise_det = 1'b0;

      // R10: boost only in fast mode on gated window lines
      tc_bits = 2'b11;
      field60 = 1'b1;
      goto(12, 10);
      chk("R10 fast window boost", boost, 1);
      advance(190);
      chk("R10 fast window after pulse boost", boost, 0);
      goto(18, 10);
      chk("R10 fast outside window boost", boost, 0);
      tc_bits = 2'b01;
      goto(12, 10);
      chk("R10 slow window boost", boost, 0);

      // R9: off forces gate and boost low on an ungated line
      tc_bits = 2'b11;
      goto(3, 50);
      loop_off = 1'b1;
      #1;
      chk("R9 off gate", pd_gate, 0);
      chk("R9 off boost", boost, 0);
      loop_off = 1'b0;

      // R8: revoke returns control to the time-constant bits
      video_ident = 1'b0;
      osd_revoke  = 1'b1;
      #1;
      chk("R8 revoke speed", speed_code, 1);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (150000) @(posedge clk);
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule